// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital control front end of a seven-bit step attenuator. Its output is a seven-bit active code in which bit k, when set, switches in an attenuation step of 0.25 dB × 2^k. The code therefore covers 0 to 31.75 dB. A mode input selects where the code comes from. One source is a three-wire serial port made of a clock, a data line and a latch enable. The other is a seven-bit parallel bus, which runs either transparently or edge-latched.

Every pin is asynchronous to the block. Each one passes through a two-flop synchronizer into the fast system clock domain, and all edge detection uses the synchronized samples. The block has no flow control. The active code is a plain level output, so the consumer cannot apply back-pressure. A one-cycle change strobe tells the consumer when a new code has taken effect. After reset, and until a source writes a new value, the active code holds maximum attenuation (all seven bits set).

Top module: `step_atten_ctrl`

## Requirements
- R1: `mode_sel` high selects serial control and `mode_sel` low selects parallel control. In parallel mode, serial clock activity has no effect on the active code.
- R2: In serial mode a rising edge of `ser_clk` shifts `ser_data` into an 8-bit word, least significant bit first. After eight clocks the first bit sent sits in bit 0. Bit k (k = 0..6) of the active code weighs 0.25 dB × 2^k.
- R3: Bit 7 of the serial word is reserved. It never reaches the active code.
- R4: While `latch_en` is high, `ser_clk` edges are ignored and the shift word holds its contents.
- R5: In serial mode, a rising edge of `latch_en` copies bits 6..0 of the shift word into the active code. Every pin change shows at the outputs three system clock edges later: two synchronizer stages plus the output register.
- R6: After reset with `mode_sel` high, `atten_code` is 7'h7F and `code_chg` is 0. The shift word also resets to 7'h7F with bit 7 clear, so a latch edge with no clocks keeps maximum attenuation.
- R7: In parallel mode with `latch_en` high, `atten_code` follows `par_code` on every cycle (direct mode).
- R8: In parallel mode with `latch_en` low, changes on `par_code` are ignored. A rising edge of `latch_en` captures `par_code` (latched mode).
- R9: After reset with `mode_sel` low and `latch_en` low, `atten_code` is 7'h7F and stays there while `par_code` changes.
- R10: If more than eight serial clocks arrive before the latch edge, only the last eight bits received are kept.
- R11: `code_chg` is high for exactly those cycles in which `atten_code` differs from its value one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | 1 = serial control, 0 = parallel control |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, least significant bit first |
| latch_en | input | 1 | Latch enable; also blocks serial clocking while high |
| par_code | input | 7 | Parallel attenuation code |
| atten_code | output | 7 | Active attenuation code, 0.25 dB per step |
| code_chg | output | 1 | One-cycle pulse when the active code changes |

## Verification
Every result is due exactly three system clock edges after the pin change that causes it: a latch-enable rise, or a parallel bus change in direct mode. The change strobe arrives on that same edge. Each driver task changes pins away from the active edge and pushes the expected code together with the cycle count at which it is due. A monitor then compares both the value and the arrival cycle whenever the strobe fires, and it flags any strobe that no expected item accounts for. Stimuli that must be ignored are checked by reading the active code well after the three-edge window and confirming that no strobe appeared.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int CODE_W    = 7;
  localparam int WORD_W    = 8;
  localparam int SYNC_DEPTH = 2;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t MAX_CODE = '1;
endpackage

// File: rtl/sac_sync.sv
module sac_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= '0;
        else        stage[i] <= stage[i-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sac_shift.sv
module sac_shift #(
  parameter int WORD_W = 8,
  parameter int CODE_W = 7,
  parameter logic [WORD_W-1:0] RST_WORD = {1'b0, {(WORD_W-1){1'b1}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              le_s,
  output logic              le_rise,
  output logic [CODE_W-1:0] shift_code
);
  logic              sclk_d;
  logic              le_d;
  logic [WORD_W-1:0] word_q;
  logic              shift_en;

  assign le_rise  = le_s & ~le_d;
  // shift only on a clock rise while the latch enable is low
  assign shift_en = sclk_s & ~sclk_d & ~le_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      le_d   <= 1'b0;
      word_q <= RST_WORD;
    end else begin
      sclk_d <= sclk_s;
      le_d   <= le_s;
      if (shift_en) word_q <= {sdat_s, word_q[WORD_W-1:1]};
    end
  end

  assign shift_code = word_q[CODE_W-1:0];
endmodule

// File: rtl/sac_active.sv
module sac_active #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_mode,
  input  logic              le_s,
  input  logic              le_rise,
  input  logic [CODE_W-1:0] shift_code,
  input  logic [CODE_W-1:0] par_s,
  output logic [CODE_W-1:0] code_q,
  output logic              chg_q
);
  logic [CODE_W-1:0] code_nxt;

  always_comb begin
    code_nxt = code_q;
    if (ser_mode) begin
      if (le_rise) code_nxt = shift_code;
    end else if (le_s) begin
      // covers both the direct path and the capturing edge
      code_nxt = par_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '1;
      chg_q  <= 1'b0;
    end else begin
      code_q <= code_nxt;
      chg_q  <= (code_nxt != code_q);
    end
  end
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import sac_pkg::*;
#(
  parameter int CW    = CODE_W,
  parameter int WW    = WORD_W,
  parameter int SYNCS = SYNC_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          ser_clk,
  input  logic          ser_data,
  input  logic          latch_en,
  input  logic [CW-1:0] par_code,
  output logic [CW-1:0] atten_code,
  output logic          code_chg
);
  localparam int CTRL_W = 4;

  logic [CTRL_W-1:0] ctrl_s;
  logic              mode_s, sclk_s, sdat_s, le_s;
  logic [CW-1:0]     par_s;
  logic              le_rise;
  logic [CW-1:0]     shift_code;

  sac_sync #(.W(CTRL_W), .STAGES(SYNCS)) u_sync_ctrl (
    .clk(clk), .rst_n(rst_n),
    .d({mode_sel, ser_clk, ser_data, latch_en}),
    .q(ctrl_s)
  );
  assign {mode_s, sclk_s, sdat_s, le_s} = ctrl_s;

  sac_sync #(.W(CW), .STAGES(SYNCS)) u_sync_par (
    .clk(clk), .rst_n(rst_n), .d(par_code), .q(par_s)
  );

  sac_shift #(.WORD_W(WW), .CODE_W(CW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .sdat_s(sdat_s), .le_s(le_s),
    .le_rise(le_rise), .shift_code(shift_code)
  );

  sac_active #(.CODE_W(CW)) u_active (
    .clk(clk), .rst_n(rst_n),
    .ser_mode(mode_s), .le_s(le_s), .le_rise(le_rise),
    .shift_code(shift_code), .par_s(par_s),
    .code_q(atten_code), .chg_q(code_chg)
  );
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_s,
  input logic          le_s,
  input logic          le_rise,
  input logic [CW-1:0] par_s,
  input logic [CW-1:0] shift_code,
  input logic [CW-1:0] atten_code,
  input logic          code_chg
);
  // R4
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_s |=> $stable(shift_code));
  // R5
  serial_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && le_rise) |=> atten_code == $past(shift_code));
  // R5
  serial_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && !le_rise) |=> $stable(atten_code));
  // R7
  direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && le_s) |=> atten_code == $past(par_s));
  // R8
  latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && !le_s) |=> $stable(atten_code));
  // R11
  strobe_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (atten_code != $past(atten_code)) |-> code_chg);
  // R11
  strobe_only_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_chg |-> (atten_code != $past(atten_code)));
endmodule

bind step_atten_ctrl sac_checker #(.CW(CW)) u_sac_checker (
  .clk(clk), .rst_n(rst_n), .mode_s(mode_s), .le_s(le_s),
  .le_rise(le_rise), .par_s(par_s), .shift_code(shift_code),
  .atten_code(atten_code), .code_chg(code_chg)
);

// File: tb/step_atten_ctrl_test.sv
module step_atten_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic       latch_en = 1'b1;
  logic [6:0] par_code = 7'h00;
  logic [6:0] atten_code;
  logic       code_chg;

  step_atten_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ser_clk(ser_clk),
    .ser_data(ser_data), .latch_en(latch_en), .par_code(par_code),
    .atten_code(atten_code), .code_chg(code_chg)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic [6:0] code; int due; string req; } exp_t;
  exp_t sbq[$];
  int n_chk = 0;
  int n_fail = 0;
  logic [6:0] model = 7'h7F;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every strobe must match the head of the scoreboard, in the due cycle
  always @(negedge clk) begin
    if (rst_n && code_chg) begin
      if (sbq.size() == 0) begin
        check("R11 unexpected strobe", int'(atten_code), int'(model));
        check("R11 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check({e.req, " code"}, int'(atten_code), int'(e.code));
        check("R11 strobe cycle", cyc, e.due);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // call right after changing pins at a negedge: result due three edges on
  task automatic expect_code(logic [6:0] c, string req);
    if (c != model) begin
      exp_t e;
      e.code = c; e.due = cyc + 3; e.req = req;
      sbq.push_back(e);
      model = c;
    end
  endtask

  task automatic ser_bit(logic b);
    ser_data = b; tick(3);
    ser_clk = 1'b1; tick(3);
    ser_clk = 1'b0; tick(3);
  endtask

  task automatic ser_write(logic [15:0] bits, int n, string req);
    logic [15:0] w;
    latch_en = 1'b0; tick(3);
    for (int i = 0; i < n; i++) ser_bit(bits[i]);
    latch_en = 1'b1;
    w = bits >> (n - 8);
    expect_code(w[6:0], req);
    tick(6);
    check(req, int'(atten_code), int'(w[6:0]));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(4);
    rst_n = 1'b1;
    model = 7'h7F;
  endtask

  initial begin
    do_reset();
    check("R6 reset code", int'(atten_code), 'h7F);
    check("R6 reset strobe", int'(code_chg), 0);
    tick(6);
    check("R6 code after idle", int'(atten_code), 'h7F);

    // R2 R5: ordinary serial word
    ser_write(16'h002A, 8, "R2");
    ser_write(16'h0055, 8, "R5");
    // R3: reserved bit set in the word
    ser_write(16'h0085, 8, "R3");

    // R4: clocks with latch high are ignored; relatch gives same code
    for (int i = 0; i < 8; i++) ser_bit(1'b1);
    latch_en = 1'b0; tick(4);
    latch_en = 1'b1; tick(6);
    check("R4 clocks blocked", int'(atten_code), 'h05);

    // R10: ten bits, last eight form 0x31
    ser_write({6'd0, 8'h31, 2'b11}, 10, "R10");

    // R8: latched parallel, bus ignored while latch low
    latch_en = 1'b0; tick(3);
    mode_sel = 1'b0; par_code = 7'h55; tick(8);
    check("R8 bus ignored", int'(atten_code), 'h31);
    latch_en = 1'b1;
    expect_code(7'h55, "R8");
    tick(6);
    check("R8 capture", int'(atten_code), 'h55);

    // R7: direct parallel follows the bus
    par_code = 7'h12; expect_code(7'h12, "R7"); tick(6);
    check("R7 direct", int'(atten_code), 'h12);
    par_code = 7'h00; expect_code(7'h00, "R7"); tick(6);
    check("R7 direct zero", int'(atten_code), 'h00);
    par_code = 7'h7F; expect_code(7'h7F, "R7"); tick(6);

    // R1: serial clocks in parallel mode do not reach the code
    latch_en = 1'b0; par_code = 7'h33; tick(3);
    for (int i = 0; i < 8; i++) ser_bit(1'b0);
    check("R1 parallel hold", int'(atten_code), 'h7F);
    latch_en = 1'b1;
    expect_code(7'h33, "R1");
    tick(6);
    check("R1 parallel source", int'(atten_code), 'h33);

    // R9: reset in parallel mode with latch low
    latch_en = 1'b0; tick(3);
    check("R11 queue drained", sbq.size(), 0);
    par_code = 7'h00;
    do_reset();
    tick(6);
    par_code = 7'h0A; tick(6);
    check("R9 parallel reset", int'(atten_code), 'h7F);

    tick(4);
    check("R11 queue empty", sbq.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule